// File: doc/BRIEF.md
# Multi-Bus Result Broadcast with Register Renaming Status

This block collects finished results from a set of producers (functional units and load buffers) and puts up to four of them per cycle onto parallel result buses. Waiting stations snoop the buses. Each bus carries a valid bit, the producer tag and a 32-bit value.

Producer `i` owns tag `i+1`. Tag 0 means "no producer". A producer raises its request with its data and holds both until it sees its acknowledge. The acknowledge is a one-cycle pulse, issued in the same cycle the result is on a bus.

Units that have nothing to write back simply never raise a request. This applies to stores, conditional branches and jumps.

Alongside the buses, the block keeps a status table and a value for each of 32 architectural registers. The table records which tag will next write each register. Issue logic reports each new producer through the issue port. It reads the current value and pending tag of its source registers through the read ports.

A broadcast updates a register only when the tag on the bus is still the one the table records. An older writer of the same register is therefore seen by the stations but never lands in the register.

Top module: `result_bus_hub`

## Requirements
- R1: While reset is asserted and right after it, no bus is valid, no acknowledge is raised, and every register reads value 0 with pending tag 0.
- R2: Granted results appear on buses 0 upward without gaps. Each bus carries tag `i+1` and the data of producer `i`. Within one cycle, bus tags are strictly ascending, with at most four buses valid.
- R3: When more than four producers request, the four lowest tags are granted. The rest keep requesting and are granted in a later cycle, again lowest tag first.
- R4: Acknowledge bit `i` is high for exactly one cycle per grant, in the cycle its result is on a bus. A request still held during its acknowledge cycle is not granted a second time.
- R5: A request raised in cycle t is on a bus in cycle t+1 (one register stage) if it wins arbitration.
- R6: An issue to register r with tag T (r not 0) makes the read port for r report pending tag T from the next cycle on.
- R7: When the tag recorded for register r is broadcast, r holds the broadcast data and pending tag 0 from the cycle after the broadcast.
- R8: When a newer tag has been recorded for r, a broadcast of an older tag leaves r's value and its newer pending tag unchanged.
- R9: When an issue to r coincides with the broadcast of r's currently recorded tag, r records the new tag and its value is not written.
- R10: Register 0 always reads value 0 and pending tag 0. An issue naming register 0 has no effect, and a later broadcast of that tag leaves register 0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 8 | Per-producer write-back request, held until acknowledged |
| req_data | input | 256 | Per-producer result, producer i in bits [32i+31:32i] |
| req_ack | output | 8 | One-cycle grant acknowledge, aligned with the broadcast |
| iss_valid | input | 1 | Issue of a new producer for a register |
| iss_reg | input | 5 | Destination register of the issued instruction |
| iss_tag | input | 4 | Tag of the new producer |
| rd_addr | input | 10 | Two register read addresses, port p in bits [5p+4:5p] |
| rd_val | output | 64 | Register values for the read ports |
| rd_tag | output | 8 | Pending producer tags for the read ports, 0 if none |
| bus_valid | output | 4 | Result bus valid bits |
| bus_tag | output | 16 | Result bus tags, bus k in bits [4k+3:4k] |
| bus_data | output | 32*4 = 128 | Result bus data, bus k in bits [32k+31:32k] |

## Verification
A wrong status entry is only visible at the read ports. It shows as a stale pending tag one cycle after the broadcast or issue that should have changed it. It also shows as a value that changes, or fails to change, in the cycle after the result is on a bus.

A wrong arbitration state shows in the very cycle after the request. The bus tag order or the acknowledge pattern differs, or a result appears twice, or never, in the stream of broadcasts the scoreboard expects.

The directed cases line up an overwrite by a newer producer, a simultaneous issue and broadcast, and more than four requests at once. This lets each of these states be told apart within two cycles of the stimulus.

// File: rtl/rbh_pkg.sv
`timescale 1ns/1ps
package rbh_pkg;
    localparam int RBH_SRC_DEF  = 8;
    localparam int RBH_BUS_DEF  = 4;
    localparam int RBH_REG_DEF  = 32;
    localparam int RBH_DW_DEF   = 32;
    localparam int RBH_RD_DEF   = 2;
endpackage

// File: rtl/rbh_arbiter.sv
`timescale 1ns/1ps
// Fixed-priority multi-grant: the lowest eligible producer indices take
// buses 0, 1, ... in ascending order; at most NUM_BUS grants per cycle.
module rbh_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int NUM_BUS = 4,
    parameter int TAG_W   = 4
) (
    input  logic [NUM_SRC-1:0]              elig,
    output logic [NUM_SRC-1:0]              grant,
    output logic [NUM_BUS-1:0]              slot_vld,
    output logic [NUM_BUS-1:0][TAG_W-1:0]   slot_tag
);
    localparam int CNT_W = $clog2(NUM_BUS + 1);

    logic [CNT_W-1:0] taken;

    always_comb begin
        grant    = '0;
        slot_vld = '0;
        slot_tag = '0;
        taken    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (int'(taken) < NUM_BUS)) begin
                grant[i]        = 1'b1;
                slot_vld[taken] = 1'b1;
                slot_tag[taken] = TAG_W'(i + 1);
                taken           = taken + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rbh_reg_status.sv
`timescale 1ns/1ps
// Register values plus pending-producer table. A bus result lands only when
// its tag equals the recorded producer; a same-cycle issue wins over it.
module rbh_reg_status #(
    parameter int NUM_REGS = 32,
    parameter int NUM_BUS  = 4,
    parameter int NUM_RD   = 2,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 4,
    parameter int RA_W     = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BUS-1:0]              bus_vld,
    input  logic [NUM_BUS-1:0][TAG_W-1:0]   bus_tag,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]  bus_data,
    input  logic                            iss_valid,
    input  logic [RA_W-1:0]                 iss_reg,
    input  logic [TAG_W-1:0]                iss_tag,
    input  logic [NUM_RD-1:0][RA_W-1:0]     rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]   rd_val,
    output logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag
);
    typedef struct packed {
        logic [NUM_REGS-1:0][TAG_W-1:0]  owner;
        logic [NUM_REGS-1:0][DATA_W-1:0] value;
    } rs_t;

    rs_t st_d, st_q;

    logic              hit;
    logic [DATA_W-1:0] hit_data;

    always_comb begin
        st_d     = st_q;
        hit      = 1'b0;
        hit_data = '0;
        // Register 0 is skipped: it is never renamed and never written.
        for (int r = 1; r < NUM_REGS; r++) begin
            hit      = 1'b0;
            hit_data = '0;
            for (int k = 0; k < NUM_BUS; k++) begin
                if (bus_vld[k] && (st_q.owner[r] != '0) &&
                    (bus_tag[k] == st_q.owner[r])) begin
                    hit      = 1'b1;
                    hit_data = bus_data[k];
                end
            end
            if (iss_valid && (int'(iss_reg) == r)) begin
                st_d.owner[r] = iss_tag;
            end else if (hit) begin
                st_d.owner[r] = '0;
                st_d.value[r] = hit_data;
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_RD; p++) begin
            rd_val[p] = st_q.value[rd_addr[p]];
            rd_tag[p] = st_q.owner[rd_addr[p]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/result_bus_hub.sv
`timescale 1ns/1ps
module result_bus_hub
    import rbh_pkg::*;
#(
    parameter int NUM_SRC  = RBH_SRC_DEF,
    parameter int NUM_BUS  = RBH_BUS_DEF,
    parameter int NUM_REGS = RBH_REG_DEF,
    parameter int DATA_W   = RBH_DW_DEF,
    parameter int NUM_RD   = RBH_RD_DEF,
    localparam int TAG_W   = $clog2(NUM_SRC + 1),
    localparam int RA_W    = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          req_valid,
    input  logic [NUM_SRC*DATA_W-1:0]   req_data,
    output logic [NUM_SRC-1:0]          req_ack,
    input  logic                        iss_valid,
    input  logic [RA_W-1:0]             iss_reg,
    input  logic [TAG_W-1:0]            iss_tag,
    input  logic [NUM_RD*RA_W-1:0]      rd_addr,
    output logic [NUM_RD*DATA_W-1:0]    rd_val,
    output logic [NUM_RD*TAG_W-1:0]     rd_tag,
    output logic [NUM_BUS-1:0]          bus_valid,
    output logic [NUM_BUS*TAG_W-1:0]    bus_tag,
    output logic [NUM_BUS*DATA_W-1:0]   bus_data
);
    typedef struct packed {
        logic [NUM_BUS-1:0]              vld;
        logic [NUM_BUS-1:0][TAG_W-1:0]   tag;
        logic [NUM_BUS-1:0][DATA_W-1:0]  data;
        logic [NUM_SRC-1:0]              ack;
    } hub_t;

    hub_t hub_d, hub_q;

    logic [NUM_SRC-1:0]              elig;
    logic [NUM_SRC-1:0]              grant;
    logic [NUM_BUS-1:0]              slot_vld;
    logic [NUM_BUS-1:0][TAG_W-1:0]   slot_tag;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_val_w;
    logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag_w;

    // A producer in its acknowledge cycle is still requesting; mask it.
    assign elig = req_valid & ~hub_q.ack;

    rbh_arbiter #(
        .NUM_SRC (NUM_SRC),
        .NUM_BUS (NUM_BUS),
        .TAG_W   (TAG_W)
    ) u_arb (
        .elig     (elig),
        .grant    (grant),
        .slot_vld (slot_vld),
        .slot_tag (slot_tag)
    );

    always_comb begin
        hub_d      = '0;
        hub_d.ack  = grant;
        hub_d.vld  = slot_vld;
        hub_d.tag  = slot_tag;
        for (int k = 0; k < NUM_BUS; k++) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (slot_vld[k] && (slot_tag[k] == TAG_W'(i + 1))) begin
                    hub_d.data[k] = req_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hub_q <= '0;
        else        hub_q <= hub_d;
    end

    rbh_reg_status #(
        .NUM_REGS (NUM_REGS),
        .NUM_BUS  (NUM_BUS),
        .NUM_RD   (NUM_RD),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .RA_W     (RA_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_vld   (hub_q.vld),
        .bus_tag   (hub_q.tag),
        .bus_data  (hub_q.data),
        .iss_valid (iss_valid),
        .iss_reg   (iss_reg),
        .iss_tag   (iss_tag),
        .rd_addr   (rd_addr),
        .rd_val    (rd_val_w),
        .rd_tag    (rd_tag_w)
    );

    assign rd_val    = rd_val_w;
    assign rd_tag    = rd_tag_w;
    assign req_ack   = hub_q.ack;
    assign bus_valid = hub_q.vld;
    assign bus_tag   = hub_q.tag;
    assign bus_data  = hub_q.data;
endmodule

// File: rtl/rbh_checker.sv
`timescale 1ns/1ps
module rbh_checker #(
    parameter int NUM_SRC = 8,
    parameter int NUM_BUS = 4,
    parameter int NUM_RD  = 2,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 4,
    parameter int RA_W    = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SRC-1:0]        req_valid,
    input logic [NUM_SRC-1:0]        req_ack,
    input logic [NUM_RD*RA_W-1:0]    rd_addr,
    input logic [NUM_RD*DATA_W-1:0]  rd_val,
    input logic [NUM_RD*TAG_W-1:0]   rd_tag,
    input logic [NUM_BUS-1:0]        bus_valid,
    input logic [NUM_BUS*TAG_W-1:0]  bus_tag
);
    // R2: every acknowledge is matched by exactly one valid bus
    assert_ack_bus_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(req_ack) == $countones(bus_valid));

    // R2: valid buses are filled from bus 0 upward with no gap
    assert_bus_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((NUM_BUS'(bus_valid + 1'b1)) & bus_valid) == '0);

    // R4: no acknowledge is high two cycles running
    assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack & $past(req_ack)) == '0);

    // R5: an acknowledge follows a request in the cycle before
    assert_ack_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack & ~$past(req_valid)) == '0);

    for (genvar k = 0; k < NUM_BUS; k++) begin : g_bus
        // R2: a valid bus carries a real producer tag
        assert_bus_tag_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            bus_valid[k] |-> ((bus_tag[k*TAG_W +: TAG_W] != '0) &&
                              (int'(bus_tag[k*TAG_W +: TAG_W]) <= NUM_SRC)));
        if (k > 0) begin : g_ord
            // R3: lower tags sit on lower buses
            assert_bus_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
                bus_valid[k] |-> (bus_tag[k*TAG_W +: TAG_W] > bus_tag[(k-1)*TAG_W +: TAG_W]));
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // R10: register 0 reads zero with no producer
        assert_reg0_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr[p*RA_W +: RA_W] == '0) |->
                ((rd_val[p*DATA_W +: DATA_W] == '0) && (rd_tag[p*TAG_W +: TAG_W] == '0)));
    end
endmodule

bind result_bus_hub rbh_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_BUS (NUM_BUS),
    .NUM_RD  (NUM_RD),
    .DATA_W  (DATA_W),
    .TAG_W   (TAG_W),
    .RA_W    (RA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .rd_addr   (rd_addr),
    .rd_val    (rd_val),
    .rd_tag    (rd_tag),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag)
);

// File: tb/sim_result_bus_hub.sv
`timescale 1ns/1ps
module sim_result_bus_hub;
    localparam int NS = 8, NB = 4, DW = 32, TW = 4, AW = 5, NR = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   req_valid = '0;
    logic [NS*DW-1:0] req_data = '0;
    logic [NS-1:0]   req_ack;
    logic            iss_valid = 1'b0;
    logic [AW-1:0]   iss_reg = '0;
    logic [TW-1:0]   iss_tag = '0;
    logic [NR*AW-1:0] rd_addr = '0;
    logic [NR*DW-1:0] rd_val;
    logic [NR*TW-1:0] rd_tag;
    logic [NB-1:0]   bus_valid;
    logic [NB*TW-1:0] bus_tag;
    logic [NB*DW-1:0] bus_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [NS-1:0] hold_mask = '0;
    logic [TW+DW-1:0] sb [$];

    always #4 clk = ~clk;

    result_bus_hub u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_ack(req_ack), .iss_valid(iss_valid), .iss_reg(iss_reg),
        .iss_tag(iss_tag), .rd_addr(rd_addr), .rd_val(rd_val), .rd_tag(rd_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Driver: raise a request and queue the broadcast it must produce.
    task automatic post(input int i, input logic [DW-1:0] d);
        req_valid[i] = 1'b1;
        req_data[i*DW +: DW] = d;
        sb.push_back({TW'(i + 1), d});
    endtask

    // Advance one edge; producers drop a request once acknowledged.
    task automatic step();
        @(posedge clk);
        #1;
        for (int i = 0; i < NS; i++)
            if (req_ack[i] && !hold_mask[i]) req_valid[i] = 1'b0;
    endtask

    task automatic issue(input int r, input int t);
        iss_valid = 1'b1;
        iss_reg = AW'(r);
        iss_tag = TW'(t);
    endtask

    // Monitor: pop the scoreboard for every valid bus, in bus order.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NB; k++) begin
                if (bus_valid[k]) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R2 unexpected broadcast", 64'(bus_tag[k*TW +: TW]), 64'd0);
                    end else begin
                        logic [TW+DW-1:0] e;
                        e = sb.pop_front();
                        chk({bus_tag[k*TW +: TW], bus_data[k*DW +: DW]} == e,
                            "R2 bus tag/data", 64'({bus_tag[k*TW +: TW], bus_data[k*DW +: DW]}),
                            64'(e));
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rd_addr = {5'd0, 5'd5};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(bus_valid == '0, "R1 bus idle", 64'(bus_valid), 0);
        chk(req_ack == '0, "R1 ack idle", 64'(req_ack), 0);
        chk(rd_val == '0 && rd_tag == '0, "R1 regs clear", 64'(rd_tag), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        step();
        @(negedge clk);
        chk(bus_valid == '0 && rd_tag == '0, "R1 after release", 64'(rd_tag), 0);

        // R6: issue r5 <- tag 3
        issue(5, 3);
        step();
        iss_valid = 1'b0;
        @(negedge clk);
        chk(rd_tag[3:0] == 4'd3, "R6 pending tag", 64'(rd_tag[3:0]), 3);

        // R5/R7: producer 2 writes r5
        post(2, 32'hA5A5_0001);
        step();
        @(negedge clk);
        chk(bus_valid == 4'b0001, "R5 one-cycle latency", 64'(bus_valid), 1);
        chk(req_ack == 8'h04, "R4 ack with bus", 64'(req_ack), 4);
        step();
        @(negedge clk);
        chk(rd_val[31:0] == 32'hA5A5_0001, "R7 value written", 64'(rd_val[31:0]), 64'hA5A5_0001);
        chk(rd_tag[3:0] == 4'd0, "R7 status cleared", 64'(rd_tag[3:0]), 0);
        chk(bus_valid == '0, "R4 no repeat", 64'(bus_valid), 0);

        // R3: six requests at once
        for (int i = 0; i < 6; i++) post(i, 32'h100 + i);
        step();
        @(negedge clk);
        chk(req_ack == 8'h0F, "R3 lowest four granted", 64'(req_ack), 64'h0F);
        chk(bus_valid == 4'b1111, "R3 four buses", 64'(bus_valid), 64'hF);
        step();
        @(negedge clk);
        chk(req_ack == 8'h30, "R3 retry granted", 64'(req_ack), 64'h30);
        chk(bus_valid == 4'b0011, "R3 retry buses", 64'(bus_valid), 3);
        step();
        @(negedge clk);
        chk(bus_valid == '0, "R3 drained", 64'(bus_valid), 0);

        // R4: request held through its ack cycle is not regranted
        hold_mask[6] = 1'b1;
        post(6, 32'hBEEF_0006);
        step();
        @(negedge clk);
        chk(req_ack == 8'h40, "R4 first grant", 64'(req_ack), 64'h40);
        step();
        @(negedge clk);
        chk(req_ack == '0 && bus_valid == '0, "R4 no second grant", 64'(req_ack), 0);
        req_valid[6] = 1'b0;
        hold_mask = '0;

        // R2: non-contiguous set of four
        post(1, 32'h2222); post(3, 32'h4444); post(6, 32'h7777); post(7, 32'h8888);
        step();
        @(negedge clk);
        chk(bus_valid == 4'hF, "R2 four buses", 64'(bus_valid), 64'hF);
        chk(req_ack == 8'hCA, "R2 ack pattern", 64'(req_ack), 64'hCA);
        step();

        // R8: r7 renamed twice, older result must not land
        rd_addr = {5'd7, 5'd9};
        issue(7, 1);
        step();
        issue(7, 2);
        step();
        iss_valid = 1'b0;
        post(0, 32'hDEAD_0000);
        step();
        step();
        @(negedge clk);
        chk(rd_val[63:32] == 32'd0, "R8 old result discarded", 64'(rd_val[63:32]), 0);
        chk(rd_tag[7:4] == 4'd2, "R8 newer tag kept", 64'(rd_tag[7:4]), 2);
        post(1, 32'hC0DE_0002);
        step();
        step();
        @(negedge clk);
        chk(rd_val[63:32] == 32'hC0DE_0002, "R7 newest lands", 64'(rd_val[63:32]), 64'hC0DE_0002);
        chk(rd_tag[7:4] == 4'd0, "R7 tag cleared", 64'(rd_tag[7:4]), 0);

        // R9: issue coincides with broadcast of recorded tag
        issue(9, 4);
        step();
        iss_valid = 1'b0;
        post(3, 32'h5555_AAAA);
        step();
        issue(9, 5);
        step();
        iss_valid = 1'b0;
        @(negedge clk);
        chk(rd_tag[3:0] == 4'd5, "R9 new tag wins", 64'(rd_tag[3:0]), 5);
        chk(rd_val[31:0] == 32'd0, "R9 no write", 64'(rd_val[31:0]), 0);

        // R10: register 0 is never renamed
        rd_addr = {5'd7, 5'd0};
        issue(0, 2);
        step();
        iss_valid = 1'b0;
        @(negedge clk);
        chk(rd_tag[3:0] == 4'd0, "R10 no rename", 64'(rd_tag[3:0]), 0);
        post(1, 32'h1234_5678);
        step();
        step();
        @(negedge clk);
        chk(rd_val[31:0] == 32'd0, "R10 stays zero", 64'(rd_val[31:0]), 0);

        step();
        chk(sb.size() == 0, "R2 all broadcasts seen", 64'(sb.size()), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule